// File: doc/BRIEF.md
# Scalar Q15 Saturating ALU

This unit executes seven scalar saturating arithmetic operations on signed Q15 and unsigned 16-bit quantities. It takes a 32-bit instruction word and two 32-bit source operands, decodes the R-type fields and computes a clamped 16-bit result. The result is returned sign-extended to the full data width. Two operations are a signed add and a signed subtract of full-width operands, clamped to the Q15 range. Three are fractional multiplies of selected halfwords. Two are an unsigned add and an unsigned subtract, clamped to 0..65535.

Operations enter through a valid/ready input stream and leave through a valid/ready output stream held in one register stage. The input is accepted only when `in_ready` is high, which is when the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds its value and no new operation is taken.

Any clamp that changes a value raises `out_sat` with the result. Each accepted saturating operation also sets a sticky overflow bit, which only `clr_sticky` or reset clears. An encoding outside the group is flagged through `out_invalid`.

Top module: `q15_sat_alu`

## Requirements
- R1: An instruction belongs to the group only when bits 6:0 are 7'b1111111, bits 14:12 are 3'b001 and bits 31:25 are one of 0x02, 0x03, 0x06, 0x0E, 0x16, 0x0A or 0x0B. Any other word gives `out_invalid`=1, `out_result`=0 and `out_sat`=0.
- R2: Code 0x02 adds and code 0x03 subtracts the sources as signed 32-bit values, exactly, then clamps the result to -32768..32767.
- R3: Codes 0x06, 0x0E and 0x16 multiply signed halfwords, shift the 32-bit product arithmetically right by 15 and clamp it to -32768..32767. Halfword selection:
  - 0x06: rs1[15:0] × rs2[15:0]
  - 0x0E: rs1[15:0] × rs2[31:16]
  - 0x16: rs1[31:16] × rs2[31:16]
  - -32768 × -32768 gives 32767.
- R4: Code 0x0A adds the sources as unsigned 32-bit values and clamps any sum above 65535 to 65535.
- R5: Code 0x0B subtracts the sources as unsigned 32-bit values. A negative difference gives 0, and a difference above 65535 gives 65535.
- R6: The 16-bit clamped value is sign-extended from bit 15 into `out_result`, so an unsigned 65535 reads as 0xFFFFFFFF.
- R7: `out_sat` is 1 exactly when the clamp changed the value.
- R8: An operation is accepted when `in_valid` and `in_ready` are both high. Its result appears with `out_valid` on the next cycle. `in_ready` equals `!out_valid || out_ready`, and the output holds its value while `out_valid` is high and `out_ready` is low.
- R9: `sticky_ov` is set on the cycle after an accepted operation saturates and stays set until `clr_sticky` is asserted. If a set and a clear fall on the same cycle, the set wins.
- R10: Synchronous active-high `rst` clears `out_valid` and `sticky_ov`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input operation valid |
| in_ready | output | 1 | Unit can accept an operation |
| insn | input | 32 | Instruction word |
| src_a | input | 32 | First source operand (rs1) |
| src_b | input | 32 | Second source operand (rs2) |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts the result |
| out_result | output | 32 | Sign-extended clamped result |
| out_sat | output | 1 | Clamp changed the value |
| out_invalid | output | 1 | Encoding not in the group |
| clr_sticky | input | 1 | Clear the sticky overflow bit |
| sticky_ov | output | 1 | Sticky overflow status |

## Verification
The bench builds the unit with its default parameters: a 32-bit data width and 16-bit lanes. At these widths the extreme operands 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF can push every adder past both the 32-bit and the 16-bit range. They also drive the single overflowing product, -32768 × -32768. Each operation is checked both at values that sit exactly on the clamp limits and at values one step beyond them. This shows that `out_sat` separates a value that fits from one that was clamped.

// File: rtl/q15_alu_pkg.sv
package q15_alu_pkg;
  typedef enum logic [2:0] {
    OP_SADD, OP_SSUB, OP_MBB, OP_MBT, OP_MTT, OP_UADD, OP_USUB, OP_NONE
  } q15_op_e;

  localparam logic [6:0] GRP_OPCODE = 7'h7F;
  localparam logic [2:0] GRP_F3     = 3'b001;
  localparam logic [6:0] F7_SADD    = 7'h02;
  localparam logic [6:0] F7_SSUB    = 7'h03;
  localparam logic [6:0] F7_MBB     = 7'h06;
  localparam logic [6:0] F7_MBT     = 7'h0E;
  localparam logic [6:0] F7_MTT     = 7'h16;
  localparam logic [6:0] F7_UADD    = 7'h0A;
  localparam logic [6:0] F7_USUB    = 7'h0B;
endpackage

// File: rtl/q15_decode.sv
module q15_decode
  import q15_alu_pkg::*;
(
  input  logic [31:0] insn,
  output q15_op_e     op,
  output logic        illegal
);
  logic [6:0] opc, f7;
  logic [2:0] f3;

  assign opc = insn[6:0];
  assign f3  = insn[14:12];
  assign f7  = insn[31:25];

  always_comb begin
    op = OP_NONE;
    if (opc == GRP_OPCODE && f3 == GRP_F3) begin
      unique case (f7)
        F7_SADD: op = OP_SADD;
        F7_SSUB: op = OP_SSUB;
        F7_MBB:  op = OP_MBB;
        F7_MBT:  op = OP_MBT;
        F7_MTT:  op = OP_MTT;
        F7_UADD: op = OP_UADD;
        F7_USUB: op = OP_USUB;
        default: op = OP_NONE;
      endcase
    end
    illegal = (op == OP_NONE);
  end
endmodule

// File: rtl/q15_exec.sv
module q15_exec
  import q15_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 16
) (
  input  q15_op_e             op,
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  output logic [DATA_W-1:0]   res,
  output logic                sat
);
  localparam int WIDE   = DATA_W + 2;
  localparam int PROD_W = 2 * LANE_W;
  localparam int SHIFT  = LANE_W - 1;
  localparam int EXT_W  = DATA_W - LANE_W;
  localparam logic signed [WIDE-1:0] S_MAX = WIDE'((64'd1 << (LANE_W - 1)) - 64'd1);
  localparam logic signed [WIDE-1:0] S_MIN = ~S_MAX;
  localparam logic [WIDE-1:0]        U_MAX = WIDE'((64'd1 << LANE_W) - 64'd1);

  logic signed [WIDE-1:0]   sa, sb, s_sum, s_dif, m_wide;
  logic [WIDE-1:0]          ua, ub, u_sum, u_dif;
  logic signed [LANE_W-1:0] hx, hy;
  logic signed [PROD_W-1:0] prod, prod_sh;
  logic [LANE_W-1:0]        lane;

  function automatic logic [LANE_W:0] clamp_s(input logic signed [WIDE-1:0] v);
    if (v > S_MAX)      return {1'b1, S_MAX[LANE_W-1:0]};
    else if (v < S_MIN) return {1'b1, S_MIN[LANE_W-1:0]};
    else                return {1'b0, v[LANE_W-1:0]};
  endfunction

  assign sa    = {{2{a[DATA_W-1]}}, a};
  assign sb    = {{2{b[DATA_W-1]}}, b};
  assign ua    = {2'b00, a};
  assign ub    = {2'b00, b};
  assign s_sum = sa + sb;
  assign s_dif = sa - sb;
  assign u_sum = ua + ub;
  assign u_dif = ua - ub;

  // halfword lane selection by operation
  assign hx      = (op == OP_MTT) ? a[PROD_W-1:LANE_W] : a[LANE_W-1:0];
  assign hy      = (op == OP_MBB) ? b[LANE_W-1:0]      : b[PROD_W-1:LANE_W];
  assign prod    = PROD_W'(hx) * PROD_W'(hy);
  assign prod_sh = prod >>> SHIFT;
  assign m_wide  = {{(WIDE-PROD_W){prod_sh[PROD_W-1]}}, prod_sh};

  always_comb begin
    lane = '0;
    sat  = 1'b0;
    unique case (op)
      OP_SADD: {sat, lane} = clamp_s(s_sum);
      OP_SSUB: {sat, lane} = clamp_s(s_dif);
      OP_MBB, OP_MBT, OP_MTT: {sat, lane} = clamp_s(m_wide);
      OP_UADD: begin
        if (u_sum > U_MAX) begin sat = 1'b1; lane = U_MAX[LANE_W-1:0]; end
        else               lane = u_sum[LANE_W-1:0];
      end
      OP_USUB: begin
        if (u_dif[WIDE-1])      begin sat = 1'b1; lane = '0; end
        else if (u_dif > U_MAX) begin sat = 1'b1; lane = U_MAX[LANE_W-1:0]; end
        else                    lane = u_dif[LANE_W-1:0];
      end
      default: begin lane = '0; sat = 1'b0; end
    endcase
  end

  assign res = {{EXT_W{lane[LANE_W-1]}}, lane};
endmodule

// File: rtl/q15_out_stage.sv
module q15_out_stage #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] res_d,
  input  logic              sat_d,
  input  logic              inv_d,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_sat,
  output logic              out_invalid,
  input  logic              clr_sticky,
  output logic              sticky_ov
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_sat     <= 1'b0;
      out_invalid <= 1'b0;
      sticky_ov   <= 1'b0;
    end else begin
      if (take) begin
        out_valid   <= 1'b1;
        out_result  <= res_d;
        out_sat     <= sat_d;
        out_invalid <= inv_d;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      sticky_ov <= (sticky_ov && !clr_sticky) || (take && sat_d);
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_sat));
  assert_accept_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);
  assert_sticky_set_R9: assert property (@(posedge clk) disable iff (rst)
    take && sat_d |=> sticky_ov);
  assert_sticky_keep_R9: assert property (@(posedge clk) disable iff (rst)
    sticky_ov && !clr_sticky |=> sticky_ov);
  assert_reset_R10: assert property (@(posedge clk)
    rst |=> !out_valid && !sticky_ov);
endmodule

// File: rtl/q15_sat_alu.sv
module q15_sat_alu
  import q15_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       insn,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_sat,
  output logic              out_invalid,
  input  logic              clr_sticky,
  output logic              sticky_ov
);
  q15_op_e           op;
  logic              illegal;
  logic [DATA_W-1:0] res_c;
  logic              sat_c;

  q15_decode u_dec (.insn(insn), .op(op), .illegal(illegal));

  q15_exec #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_exec (
    .op(op), .a(src_a), .b(src_b), .res(res_c), .sat(sat_c)
  );

  q15_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .res_d(res_c), .sat_d(sat_c), .inv_d(illegal),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_sat(out_sat), .out_invalid(out_invalid),
    .clr_sticky(clr_sticky), .sticky_ov(sticky_ov)
  );

  assert_invalid_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_invalid |-> out_result == '0 && !out_sat);
  assert_sext_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_result[DATA_W-1:LANE_W] == {(DATA_W-LANE_W){out_result[LANE_W-1]}});
endmodule

// File: tb/q15_sat_alu_tb_top.sv
module q15_sat_alu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 26;

  logic        clk = 1'b0;
  logic        rst, in_valid, in_ready, out_valid, out_ready;
  logic        out_sat, out_invalid, clr_sticky, sticky_ov;
  logic [31:0] insn, src_a, src_b, out_result;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  q15_sat_alu dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .insn(insn), .src_a(src_a), .src_b(src_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_sat(out_sat), .out_invalid(out_invalid),
    .clr_sticky(clr_sticky), .sticky_ov(sticky_ov)
  );

  // {funct7, rs1, rs2, expected result, expected saturation}
  localparam logic [103:0] VEC [NV] = '{
    {7'h02, 32'h00000001, 32'h00000002, 32'h00000003, 1'b0},
    {7'h02, 32'h00007FFF, 32'h00000001, 32'h00007FFF, 1'b1},
    {7'h02, 32'h80000000, 32'hFFFFFFFF, 32'hFFFF8000, 1'b1},
    {7'h02, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 1'b0},
    {7'h02, 32'hFFFF8000, 32'h00000000, 32'hFFFF8000, 1'b0},
    {7'h03, 32'h00000000, 32'h00000001, 32'hFFFFFFFF, 1'b0},
    {7'h03, 32'hFFFF8000, 32'h00000001, 32'hFFFF8000, 1'b1},
    {7'h03, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h00007FFF, 1'b1},
    {7'h06, 32'h00004000, 32'h00004000, 32'h00002000, 1'b0},
    {7'h06, 32'h00008000, 32'h00008000, 32'h00007FFF, 1'b1},
    {7'h06, 32'h00008000, 32'h00007FFF, 32'hFFFF8001, 1'b0},
    {7'h06, 32'h0000FFFF, 32'h00000001, 32'hFFFFFFFF, 1'b0},
    {7'h0E, 32'h12344000, 32'h7FFF0000, 32'h00003FFF, 1'b0},
    {7'h0E, 32'h00008000, 32'h80000005, 32'h00007FFF, 1'b1},
    {7'h16, 32'hC0000000, 32'h40000000, 32'hFFFFE000, 1'b0},
    {7'h16, 32'h80001111, 32'h80002222, 32'h00007FFF, 1'b1},
    {7'h0A, 32'h00000001, 32'h00000002, 32'h00000003, 1'b0},
    {7'h0A, 32'h00008000, 32'h00007FFF, 32'hFFFFFFFF, 1'b0},
    {7'h0A, 32'h0000FFFF, 32'h00000001, 32'hFFFFFFFF, 1'b1},
    {7'h0A, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1},
    {7'h0A, 32'h00007FFF, 32'h00000000, 32'h00007FFF, 1'b0},
    {7'h0B, 32'h00000005, 32'h00000003, 32'h00000002, 1'b0},
    {7'h0B, 32'h00000003, 32'h00000005, 32'h00000000, 1'b1},
    {7'h0B, 32'hFFFFFFFF, 32'h00000000, 32'hFFFFFFFF, 1'b1},
    {7'h0B, 32'h80000000, 32'h7FFFFFFF, 32'h00000001, 1'b0},
    {7'h0B, 32'h00008000, 32'h00000000, 32'hFFFF8000, 1'b0}
  };

  function automatic logic [31:0] mk(input logic [6:0] f7);
    return {f7, 5'd2, 5'd1, 3'b001, 5'd3, 7'h7F};
  endfunction

  function automatic string req_of(input logic [6:0] f7);
    case (f7)
      7'h02, 7'h03: return "R2/R6";
      7'h0A:        return "R4/R6";
      7'h0B:        return "R5/R6";
      default:      return "R3/R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one accepted operation; outputs sampled at the following negedge
  task automatic issue(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    insn = w; src_a = a; src_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1; clr_sticky = 1'b0;
    insn = '0; src_a = '0; src_b = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check("R10 out_valid after reset", {31'b0, out_valid}, 32'd0);
    check("R10 sticky after reset", {31'b0, sticky_ov}, 32'd0);
    check("R8 in_ready when empty", {31'b0, in_ready}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      logic [6:0]  f7;
      logic [31:0] a, b, e;
      logic        s;
      {f7, a, b, e, s} = VEC[i];
      issue(mk(f7), a, b);
      check("R8 out_valid", {31'b0, out_valid}, 32'd1);
      check(req_of(f7), out_result, e);
      check("R7 saturation", {31'b0, out_sat}, {31'b0, s});
      check("R1 valid encoding", {31'b0, out_invalid}, 32'd0);
    end

    // R1 illegal encodings
    issue({7'h7F, 5'd2, 5'd1, 3'b001, 5'd3, 7'h7F}, 32'h00007FFF, 32'h1);
    check("R1 bad funct7 invalid", {31'b0, out_invalid}, 32'd1);
    check("R1 bad funct7 result", out_result, 32'd0);
    check("R1 bad funct7 sat", {31'b0, out_sat}, 32'd0);
    issue({7'h02, 5'd2, 5'd1, 3'b001, 5'd3, 7'h33}, 32'h1, 32'h2);
    check("R1 bad opcode invalid", {31'b0, out_invalid}, 32'd1);
    check("R1 bad opcode result", out_result, 32'd0);
    issue({7'h02, 5'd2, 5'd1, 3'b000, 5'd3, 7'h7F}, 32'h1, 32'h2);
    check("R1 bad funct3 invalid", {31'b0, out_invalid}, 32'd1);

    // R9 sticky behaviour
    @(negedge clk); clr_sticky = 1'b1;
    @(negedge clk); clr_sticky = 1'b0;
    check("R9 sticky cleared", {31'b0, sticky_ov}, 32'd0);
    issue(mk(7'h02), 32'h1, 32'h1);
    check("R9 no set without clamp", {31'b0, sticky_ov}, 32'd0);
    issue(mk(7'h0B), 32'h0, 32'h1);
    check("R9 set by clamp", {31'b0, sticky_ov}, 32'd1);
    issue(mk(7'h02), 32'h1, 32'h1);
    repeat (3) @(negedge clk);
    check("R9 sticky persists", {31'b0, sticky_ov}, 32'd1);
    @(negedge clk);
    clr_sticky = 1'b1; insn = mk(7'h06); src_a = 32'h8000; src_b = 32'h8000; in_valid = 1'b1;
    @(negedge clk);
    clr_sticky = 1'b0; in_valid = 1'b0;
    check("R9 set wins over clear", {31'b0, sticky_ov}, 32'd1);

    // R8 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    insn = mk(7'h02); src_a = 32'd10; src_b = 32'd20; in_valid = 1'b1;
    @(negedge clk);
    check("R8 captured under stall", out_result, 32'd30);
    check("R8 in_ready low when full", {31'b0, in_ready}, 32'd0);
    insn = mk(7'h03); src_a = 32'd100; src_b = 32'd1;
    repeat (2) @(negedge clk);
    check("R8 result held", out_result, 32'd30);
    check("R8 valid held", {31'b0, out_valid}, 32'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 next accepted on drain", out_result, 32'd99);
    @(negedge clk);
    check("R8 valid drops when drained", {31'b0, out_valid}, 32'd0);

    // R10 reset mid-run
    issue(mk(7'h0A), 32'hFFFF, 32'h1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 reset clears valid", {31'b0, out_valid}, 32'd0);
    check("R10 reset clears sticky", {31'b0, sticky_ov}, 32'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule